// File: doc/BRIEF.md
# Paged Flash Protection Register Bank

This block holds the protection controls for four flash array modules. The CPU reaches them through one shared four-byte register window. A page-select input decides which module's pair of registers the window currently reaches. Each module has two registers. The first is a lock register, which can be written only once in normal operating mode. The second is a configuration register that holds a boot-protect bit. While the lock is set, or while the module reports that it is enabled for programming, the boot-protect bit is frozen.

Alongside the registers the block gives a per-module boot-protect flag. It also gives a combinational permit answer for a program or erase request at a given address and program page. The page number selects the module; its least significant bit gives the page parity. An odd page adds a second boot region.

Top module: `flash_guard_bank`

## Requirements
- R1: Offset 0xF4 reaches the lock register and offset 0xF5 reaches the configuration register of the module chosen by `page_sel`. A write changes only that module.
- R2: After reset every lock bit is 0 and every boot-protect bit is 1. Reads at 0xF4 return 0x00, reads at 0xF5 return 0x01, and `boot_prot` is all ones.
- R3: Only bit 0 of written data is stored. Bits 7 to 1 of every read are 0.
- R4: In normal mode (`special_mode`=0), only the first lock write to a module after reset takes effect. Every later normal-mode lock write to that module is ignored.
- R5: In special mode (`special_mode`=1), the lock register takes every write, with no once-only limit.
- R6: A configuration write is ignored while that module's lock bit is 1.
- R7: A configuration write is ignored while `prog_en` for that module is 1.
- R8: `boot_prot[m]` equals the stored boot-protect bit of module m.
- R9: The boot block is 0xE000–0xFFFF for every page. For pages with `chk_page[0]`=1 it also includes 0xA000–0xBFFF. The module checked is `chk_page[2:1]`.
- R10: `chk_permit` is 0 exactly when `chk_addr` lies in the boot block and that module's boot-protect bit is 1. Otherwise it is 1.
- R11: Writes to offsets 0xF6, 0xF7 and any offset outside the window change no state. Reads of those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 8 | Register-space byte offset |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |
| page_sel | input | 2 | Picks which module the register window reaches |
| special_mode | input | 1 | 1 = special mode, 0 = normal mode |
| prog_en | input | 4 | Program-enable status, one bit per module |
| boot_prot | output | 4 | Boot-protect flag, one bit per module |
| chk_addr | input | 16 | Address of a program/erase request |
| chk_page | input | 3 | Program page of the request (bits 2:1 give the module, bit 0 the parity) |
| chk_permit | output | 1 | 1 = request allowed, 0 = denied |

## Verification
A wrong once-only flag or lock bit shows up at the first normal-mode lock write that follows the fault. The readback at 0xF4 in the next cycle then differs from the expected value. A bad boot-protect bit shows on `boot_prot` one cycle after the faulty write. In the same cycle it flips `chk_permit` for requests inside the boot block. Write-decode faults that land on the wrong page show when the modules are swept after every write, because each sweep reads back all four modules.

// File: rtl/flash_guard_pkg.sv
// Package: flash_guard_pkg
// Shared sizes and window offsets for the paged flash protection bank.
// Assumes the module count is a power of two; the page-select input is
// its log2 width.
package flash_guard_pkg;
    localparam int NUM_MOD    = 4;
    localparam int MOD_W      = $clog2(NUM_MOD);
    localparam int CHK_PAGE_W = MOD_W + 1;
    localparam int DATA_W     = 8;
    localparam int CHK_ADDR_W = 16;

    localparam logic [7:0] OFS_LOCK = 8'hF4;
    localparam logic [7:0] OFS_CFG  = 8'hF5;

    localparam logic [CHK_ADDR_W-1:0] TOP_BOOT_LO = 16'hE000;
    localparam logic [CHK_ADDR_W-1:0] ODD_BOOT_LO = 16'hA000;
    localparam logic [CHK_ADDR_W-1:0] ODD_BOOT_HI = 16'hBFFF;
endpackage

// File: rtl/fg_module_regs.sv
// Module: fg_module_regs
// One flash module's lock bit, once-written flag and boot-protect bit.
// Assumes: lock_we and cfg_we are single-cycle strobes that the window
// decoder has already qualified with the page select.
module fg_module_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic special_mode,
    input  logic prog_en,
    input  logic lock_we,
    input  logic cfg_we,
    input  logic wbit,
    output logic lock_q,
    output logic bootp_q
);
    logic once_q;

    // Lock bit and once flag: unlimited in special mode, first write only in normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            once_q <= 1'b0;
        end else if (lock_we) begin
            if (special_mode) begin
                lock_q <= wbit;
            end else if (!once_q) begin
                lock_q <= wbit;
                once_q <= 1'b1;
            end
        end
    end

    // Boot-protect bit: changes only while unlocked and not program-enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bootp_q <= 1'b1;
        end else if (cfg_we && !lock_q && !prog_en) begin
            bootp_q <= wbit;
        end
    end

    // R4: a normal-mode lock write after the first one leaves the lock unchanged
    a_r4_lock_once: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_we && !special_mode && once_q) |=> $stable(lock_q));

    // R6: a configuration write while locked leaves boot-protect unchanged
    a_r6_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && lock_q) |=> $stable(bootp_q));

    // R7: a configuration write while program-enabled leaves boot-protect unchanged
    a_r7_cfg_progen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && prog_en) |=> $stable(bootp_q));
endmodule

// File: rtl/fg_window.sv
// Module: fg_window
// Decodes the shared register window. It turns a CPU write into a per-module
// strobe and muxes the selected module's registers onto the read bus.
// Assumes: reads are combinational; offsets outside 0xF4/0xF5 read zero.
module fg_window
    import flash_guard_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          cpu_addr,
    input  logic                cpu_wr,
    input  logic [MOD_W-1:0]    page_sel,
    input  logic [NUM_MOD-1:0]  lock_vec,
    input  logic [NUM_MOD-1:0]  bootp_vec,
    output logic [NUM_MOD-1:0]  lock_we,
    output logic [NUM_MOD-1:0]  cfg_we,
    output logic [DATA_W-1:0]   rdata
);
    logic hit_lock;
    logic hit_cfg;

    assign hit_lock = (cpu_addr == OFS_LOCK);
    assign hit_cfg  = (cpu_addr == OFS_CFG);

    // One write strobe per module, raised only for the selected page.
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_strobe
        assign lock_we[m] = cpu_wr && hit_lock && (page_sel == MOD_W'(m));
        assign cfg_we[m]  = cpu_wr && hit_cfg  && (page_sel == MOD_W'(m));
    end

    // Read mux: bit 0 from the selected register, upper bits always zero.
    always_comb begin
        rdata = '0;
        if (hit_lock)     rdata[0] = lock_vec[page_sel];
        else if (hit_cfg) rdata[0] = bootp_vec[page_sel];
    end

    // R1: at most one register strobe per write
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lock_we, cfg_we}));

    // R11: offsets other than lock/config never strobe a register
    a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_lock && !hit_cfg) |-> (lock_we == '0 && cfg_we == '0));
endmodule

// File: rtl/fg_permit.sv
// Module: fg_permit
// Combinational program/erase permit check. It finds whether the address
// falls in the boot block of the given page, then consults that module's
// boot-protect bit.
// Assumes: chk_page[MOD_W:1] names the module, chk_page[0] is the parity.
module fg_permit
    import flash_guard_pkg::*;
(
    input  logic [CHK_ADDR_W-1:0] chk_addr,
    input  logic [CHK_PAGE_W-1:0] chk_page,
    input  logic [NUM_MOD-1:0]    bootp_vec,
    output logic                  in_boot,
    output logic                  permit
);
    logic              odd_hit;
    logic [MOD_W-1:0]  mod_idx;

    // Region match: the top block always, the middle block on odd pages.
    always_comb begin
        odd_hit = chk_page[0] && (chk_addr >= ODD_BOOT_LO) && (chk_addr <= ODD_BOOT_HI);
        in_boot = (chk_addr >= TOP_BOOT_LO) || odd_hit;
        mod_idx = chk_page[CHK_PAGE_W-1:1];
        permit  = !(in_boot && bootp_vec[mod_idx]);
    end

    // R9: the top region is in the boot block on every page
    a_r9_top_region: assert final (!(chk_addr >= TOP_BOOT_LO) || in_boot);
endmodule

// File: rtl/flash_guard_bank.sv
// Module: flash_guard_bank (top)
// Four-way banked lock/boot-protect registers behind one register window,
// plus a permit check for program/erase requests.
// Assumes: a synchronous active-low reset; cpu_wr is held for one cycle per write.
module flash_guard_bank
    import flash_guard_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            cpu_addr,
    input  logic                  cpu_wr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    output logic [DATA_W-1:0]     cpu_rdata,
    input  logic [MOD_W-1:0]      page_sel,
    input  logic                  special_mode,
    input  logic [NUM_MOD-1:0]    prog_en,
    output logic [NUM_MOD-1:0]    boot_prot,
    input  logic [CHK_ADDR_W-1:0] chk_addr,
    input  logic [CHK_PAGE_W-1:0] chk_page,
    output logic                  chk_permit
);
    logic [NUM_MOD-1:0] lock_we;
    logic [NUM_MOD-1:0] cfg_we;
    logic [NUM_MOD-1:0] lock_vec;
    logic [NUM_MOD-1:0] bootp_vec;
    logic               in_boot;
    logic               unused_wdata;

    assign unused_wdata = ^cpu_wdata[DATA_W-1:1];

    fg_window u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .page_sel  (page_sel),
        .lock_vec  (lock_vec),
        .bootp_vec (bootp_vec),
        .lock_we   (lock_we),
        .cfg_we    (cfg_we),
        .rdata     (cpu_rdata)
    );

    // One register pair per flash module.
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
        fg_module_regs u_regs (
            .clk          (clk),
            .rst_n        (rst_n),
            .special_mode (special_mode),
            .prog_en      (prog_en[m]),
            .lock_we      (lock_we[m]),
            .cfg_we       (cfg_we[m]),
            .wbit         (cpu_wdata[0]),
            .lock_q       (lock_vec[m]),
            .bootp_q      (bootp_vec[m])
        );
    end

    assign boot_prot = bootp_vec;

    fg_permit u_permit (
        .chk_addr  (chk_addr),
        .chk_page  (chk_page),
        .bootp_vec (bootp_vec),
        .in_boot   (in_boot),
        .permit    (chk_permit)
    );

    // R3: upper read bits are always zero
    a_r3_rd_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[DATA_W-1:1] == '0);

    // R10: a boot-block request on a protected module is denied
    a_r10_deny: assert property (@(posedge clk) disable iff (!rst_n)
        (in_boot && boot_prot[chk_page[CHK_PAGE_W-1:1]]) |-> !chk_permit);

    // R5: a special-mode lock write lands on the next cycle
    a_r5_special_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && special_mode && cpu_addr == OFS_LOCK)
        |=> (lock_vec[$past(page_sel)] == $past(cpu_wdata[0])));
endmodule

// File: tb/flash_guard_bank_test.sv
module flash_guard_bank_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cpu_addr;
    logic        cpu_wr;
    logic [7:0]  cpu_wdata;
    logic [7:0]  cpu_rdata;
    logic [1:0]  page_sel;
    logic        special_mode;
    logic [3:0]  prog_en;
    logic [3:0]  boot_prot;
    logic [15:0] chk_addr;
    logic [2:0]  chk_page;
    logic        chk_permit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [3:0] m_lock, m_bp, m_once;

    always #5 clk = ~clk;

    flash_guard_bank uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .page_sel(page_sel),
        .special_mode(special_mode), .prog_en(prog_en), .boot_prot(boot_prot),
        .chk_addr(chk_addr), .chk_page(chk_page), .chk_permit(chk_permit)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_permit(input logic [15:0] a, input logic [2:0] pg, input logic [3:0] bp);
        logic hit;
        hit = (a >= 16'hE000) || (pg[0] && a >= 16'hA000 && a <= 16'hBFFF);
        return !(hit && bp[pg[2:1]]);
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic [1:0] pg,
                            input logic sp, input logic [3:0] pe);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; page_sel = pg; special_mode = sp; prog_en = pe; cpu_wr = 1'b1;
        @(posedge clk);
        #1;
        cpu_wr = 1'b0;
        if (a == 8'hF4) begin
            if (sp) m_lock[pg] = d[0];
            else if (!m_once[pg]) begin m_lock[pg] = d[0]; m_once[pg] = 1'b1; end
        end else if (a == 8'hF5) begin
            if (!m_lock[pg] && !pe[pg]) m_bp[pg] = d[0];
        end
    endtask

    task automatic sweep(input string tag);
        for (int m = 0; m < 4; m++) begin
            page_sel = m[1:0];
            cpu_addr = 8'hF4; #1;
            check({tag, " R1 R3 lock rd"}, {8'h0, cpu_rdata}, {15'h0, m_lock[m]});
            cpu_addr = 8'hF5; #1;
            check({tag, " R1 R3 cfg rd"}, {8'h0, cpu_rdata}, {15'h0, m_bp[m]});
        end
        check({tag, " R8 boot_prot"}, {12'h0, boot_prot}, {12'h0, m_bp});
    endtask

    task automatic permit_at(input logic [15:0] a, input logic [2:0] pg, input string req);
        chk_addr = a; chk_page = pg; #1;
        check(req, {15'h0, chk_permit}, {15'h0, exp_permit(a, pg, m_bp)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] corners [12];
        void'($urandom(32'h5EED1234));
        corners = '{16'h9FFF, 16'hA000, 16'hA001, 16'hBFFF, 16'hC000, 16'hDFFF,
                    16'hE000, 16'hFFFF, 16'h0000, 16'hB000, 16'h7FFF, 16'hE7FF};
        rst_n = 1'b0; cpu_addr = 8'h0; cpu_wr = 1'b0; cpu_wdata = 8'h0; page_sel = 2'd0;
        special_mode = 1'b0; prog_en = 4'h0; chk_addr = 16'h0; chk_page = 3'd0;
        m_lock = 4'h0; m_bp = 4'hF; m_once = 4'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: reset values
        sweep("R2 reset");
        // R9 R10: region corners with every module protected
        for (int p = 0; p < 8; p++)
            for (int k = 0; k < 12; k++) permit_at(corners[k], p[2:0], "R9 R10 permit protected");

        // R11: writes to F6/F7/outside have no effect; reads are zero
        do_write(8'hF6, 8'hFE, 2'd1, 1'b0, 4'h0);
        do_write(8'hF7, 8'hFF, 2'd1, 1'b1, 4'h0);
        do_write(8'h20, 8'hFF, 2'd1, 1'b0, 4'h0);
        page_sel = 2'd1; cpu_addr = 8'hF6; #1; check("R11 rd F6", {8'h0, cpu_rdata}, 16'h0);
        cpu_addr = 8'hF7; #1; check("R11 rd F7", {8'h0, cpu_rdata}, 16'h0);
        sweep("R11 after ignored writes");

        // R7: program-enable blocks the config write
        do_write(8'hF5, 8'h00, 2'd2, 1'b0, 4'b0100);
        sweep("R7 prog_en block");
        // R3: clearing boot-protect with upper data bits set; R1 other modules kept
        do_write(8'hF5, 8'hFE, 2'd2, 1'b0, 4'b1011);
        sweep("R3 R1 cfg clear");
        for (int k = 0; k < 12; k++) permit_at(corners[k], 3'd5, "R10 permit unprotected");
        // R4: first normal lock write sticks, later ones ignored
        do_write(8'hF4, 8'h01, 2'd2, 1'b0, 4'h0);
        do_write(8'hF4, 8'h00, 2'd2, 1'b0, 4'h0);
        sweep("R4 lock once");
        // R6: config blocked while locked
        do_write(8'hF5, 8'h01, 2'd2, 1'b0, 4'h0);
        sweep("R6 locked cfg");
        // R5: special mode rewrites the lock freely
        do_write(8'hF4, 8'h00, 2'd2, 1'b1, 4'h0);
        do_write(8'hF4, 8'h01, 2'd2, 1'b1, 4'h0);
        do_write(8'hF4, 8'h00, 2'd2, 1'b1, 4'h0);
        sweep("R5 special rewrite");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [3:0] sel;
            sel = 4'($urandom_range(0, 9));
            a = (sel < 4) ? 8'hF4 : (sel < 8) ? 8'hF5 : (sel == 8) ? 8'hF6 : 8'($urandom);
            do_write(a, 8'($urandom), 2'($urandom), ($urandom_range(0, 7) == 0),
                     4'($urandom) & 4'($urandom));
            sweep("rand R4 R5 R6 R7");
            permit_at(($urandom_range(0, 1) == 1) ? corners[$urandom_range(0, 11)] : 16'($urandom),
                      3'($urandom), "rand R9 R10");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule